// File: doc/BRIEF.md
# Page-Bounded Block DMA Engine

This block is a bus-mastering copy engine. Software sets up a physical start address, a word count and a direction through four memory-mapped registers, then sets a start bit. From then on the engine works alone: it asks an external arbiter for the memory bus and moves the block in bursts. Each burst has one address phase and up to four data beats. The data runs between memory and a device-side FIFO interface, either from the device into memory or from memory out to the device.

Addresses are physical, so one job may not leave its 4 KB page. The page check is made at the moment of the start write. A job that would run past the end of its page moves no data. It only sets an error flag. The interrupt line is high whenever the done flag or the error flag is set, so the processor hears from the engine only at the end of a job or on a rejected job. Between bursts the engine drops its bus request, which lets other masters win arbitration.

Top module: `blk_dma`

## Requirements
- R1: After reset every register reads zero, and `irq`, `bus_req`, `mem_cmd_valid`, `src_ready` and `snk_valid` are low.
- R2: Register map on `reg_sel`:
  - 0 is the byte address. Bits 1:0 always read as 0.
  - 1 is the length in 32-bit words.
  - 2 is control: bit 0 is start, and bit 1 is direction (0 moves device to memory, 1 moves memory to device). Bit 1 reads back.
  - 3 is status: bit 0 busy, bit 1 done, bit 2 error.
  - `reg_rdata` reflects `reg_sel` in the same cycle, and a write is visible from the next cycle.
- R3: `mem_cmd_valid` is asserted only while `bus_req` and `bus_gnt` are both high. Between two bursts of one job, `bus_req` is low for at least one cycle.
- R4: Every burst issues exactly one single-cycle command.
  - Its beat count is 4, except for the last burst, which carries the remaining 1 to 3 words.
  - The burst addresses start at the programmed address and grow by 16 bytes per burst.
  - `mem_cmd_write` is 1 when the job moves data from the device to memory.
- R5: In device-to-memory jobs, the words accepted from the source are written in order to consecutive word addresses. The word after the block stays unchanged.
- R6: In memory-to-device jobs, the memory words are delivered to the sink in address order.
- R7: The cycle after the last data beat, busy reads 0, done reads 1 and `irq` is high.
- R8: A start is rejected when the start address modulo 4096, plus 4 times the length, exceeds 4096.
  - The cycle after the start write, error reads 1 and busy reads 0.
  - `irq` goes high, and no bus request or command is issued.
  - A block that ends exactly on the page boundary is accepted.
- R9: Writing status with bit 1 set clears done, and writing it with bit 2 set clears error. A 0 bit leaves its flag alone. `irq` equals (done OR error).
- R10: While busy, writes to start, direction, address and length are ignored. The running job completes unchanged, and the registers keep their values.
- R11: A start with length 0 sets done in the next cycle and issues no bus traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_sel) |
| irq | output | 1 | Interrupt, high while done or error is set |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_cmd_valid | output | 1 | Burst address phase |
| mem_cmd_addr | output | AW | Burst start byte address |
| mem_cmd_write | output | 1 | 1 = memory write burst |
| mem_cmd_beats | output | BW | Beats in this burst |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | 32 | Write beat data |
| mem_wready | input | 1 | Memory accepts write beat |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| mem_rready | output | 1 | Engine accepts read beat |
| src_valid | input | 1 | Device source word valid |
| src_data | input | 32 | Device source word |
| src_ready | output | 1 | Engine takes source word |
| snk_valid | output | 1 | Word for device sink valid |
| snk_data | output | 32 | Word for device sink |
| snk_ready | input | 1 | Device sink accepts word |

## Verification
The results of a register write follow one edge later. Busy, the length-0 done and the page-cross error all appear in the status readback on the falling edge after the write's rising edge. The bench therefore reads status at the next falling edge, with `reg_rdata` settling combinationally. Done and `irq` appear one edge after the last accepted beat, so the bench polls status at every falling edge and checks the data only once busy has fallen. Burst commands and their beat counts are checked at the very edge that accepts them, against a running expectation of the next address and the remaining word count.

// File: rtl/blk_dma.sv
module blk_dma #(
  parameter int AW = 32,
  parameter int LW = 11,
  parameter int BURST = 4,
  parameter int PAGE_BYTES = 4096,
  localparam int BW = $clog2(BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_cmd_valid,
  output logic [AW-1:0] mem_cmd_addr,
  output logic          mem_cmd_write,
  output logic [BW-1:0] mem_cmd_beats,
  output logic          mem_wvalid,
  output logic [31:0]   mem_wdata,
  input  logic          mem_wready,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          mem_rready,
  input  logic          src_valid,
  input  logic [31:0]   src_data,
  output logic          src_ready,
  output logic          snk_valid,
  output logic [31:0]   snk_data,
  input  logic          snk_ready
);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam int EW = PB + LW + 3;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CMD, S_DATA, S_REL} st_t;
  st_t state;

  logic [AW-1:0] cfg_addr, ptr;
  logic [LW-1:0] cfg_len, left;
  logic          cfg_dir, done_f, err_f;
  logic [BW-1:0] beats_left;

  wire busy = (state != S_IDLE);
  wire [EW-1:0] span = EW'(cfg_addr[PB-1:0]) + (EW'(cfg_len) << 2);
  wire crosses = span > EW'(PAGE_BYTES);
  wire start = reg_wr && reg_sel == 2'd2 && reg_wdata[0] && !busy;
  wire in_data = (state == S_DATA);
  wire fire = in_data && (cfg_dir ? (mem_rvalid && snk_ready) : (src_valid && mem_wready));
  wire [BW-1:0] next_beats = (left >= LW'(BURST)) ? BW'(BURST) : BW'(left);

  assign irq = done_f | err_f;
  assign bus_req = (state == S_REQ) || (state == S_CMD) || in_data;
  assign mem_cmd_valid = (state == S_CMD);
  assign mem_cmd_addr = ptr;
  assign mem_cmd_write = !cfg_dir;
  assign mem_cmd_beats = next_beats;
  assign mem_wvalid = in_data && !cfg_dir && src_valid;
  assign mem_wdata = src_data;
  assign src_ready = in_data && !cfg_dir && mem_wready;
  assign snk_valid = in_data && cfg_dir && mem_rvalid;
  assign snk_data = mem_rdata;
  assign mem_rready = in_data && cfg_dir && snk_ready;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = 32'(cfg_addr);
      2'd1:    reg_rdata = 32'(cfg_len);
      2'd2:    reg_rdata = {30'd0, cfg_dir, 1'b0};
      default: reg_rdata = {29'd0, err_f, done_f, busy};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cfg_addr   <= '0;
      cfg_len    <= '0;
      cfg_dir    <= 1'b0;
      done_f     <= 1'b0;
      err_f      <= 1'b0;
      ptr        <= '0;
      left       <= '0;
      beats_left <= '0;
    end else begin
      if (reg_wr && !busy) begin
        case (reg_sel)
          2'd0:    cfg_addr <= {reg_wdata[AW-1:2], 2'b00};
          2'd1:    cfg_len  <= reg_wdata[LW-1:0];
          2'd2:    cfg_dir  <= reg_wdata[1];
          default: ;
        endcase
      end
      if (reg_wr && reg_sel == 2'd3) begin
        if (reg_wdata[1]) done_f <= 1'b0;
        if (reg_wdata[2]) err_f  <= 1'b0;
      end
      if (start) begin
        if (crosses) err_f <= 1'b1;
        else if (cfg_len == '0) done_f <= 1'b1;
        else begin
          state <= S_REQ;
          ptr   <= cfg_addr;
          left  <= cfg_len;
        end
      end
      case (state)
        S_REQ: if (bus_gnt) state <= S_CMD;
        S_CMD: begin
          beats_left <= next_beats;
          state      <= S_DATA;
        end
        S_DATA: if (fire) begin
          ptr        <= ptr + AW'(4);
          left       <= left - LW'(1);
          beats_left <= beats_left - BW'(1);
          if (beats_left == BW'(1)) begin
            if (left == LW'(1)) begin
              state  <= S_IDLE;
              done_f <= 1'b1;
            end else state <= S_REL;
          end
        end
        S_REL: state <= S_REQ;
        default: ;
      endcase
    end
  end
endmodule

module blk_dma_props #(
  parameter int BURST = 4,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_cmd_valid,
  input logic [BW-1:0] mem_cmd_beats,
  input logic          src_ready,
  input logic          snk_valid,
  input logic [31:0]   reg_rdata,
  input logic [1:0]    reg_sel,
  input logic          done_f,
  input logic          err_f
);
  assert_cmd_has_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (bus_req && bus_gnt));
  assert_beats_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (mem_cmd_beats >= BW'(1) && mem_cmd_beats <= BW'(BURST)));
  assert_single_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |=> !mem_cmd_valid);
  assert_one_direction_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_ready && snk_valid));
  assert_error_no_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_f) && reg_sel == 2'd3) |-> !reg_rdata[0]);
  assert_done_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_f) && reg_sel == 2'd3) |-> !reg_rdata[0]);
endmodule

bind blk_dma blk_dma_props #(.BURST(BURST), .BW(BW)) u_props (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_beats(mem_cmd_beats),
  .src_ready(src_ready), .snk_valid(snk_valid), .reg_rdata(reg_rdata),
  .reg_sel(reg_sel), .done_f(done_f), .err_f(err_f)
);

// File: tb/blk_dma_test.sv
module blk_dma_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        reg_wr = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq, bus_req, bus_gnt = 0;
  logic        mem_cmd_valid, mem_cmd_write;
  logic [31:0] mem_cmd_addr;
  logic [2:0]  mem_cmd_beats;
  logic        mem_wvalid, mem_wready = 0, mem_rvalid = 0, mem_rready;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic        src_valid = 0, src_ready, snk_valid, snk_ready = 0;
  logic [31:0] src_data, snk_data;

  blk_dma uut (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:4095];
  logic [31:0] got [0:1023];
  int got_n = 0;
  int src_k = 0;
  int bl = 0, cmd_cnt = 0, xfer_cmds = 0;
  logic [31:0] baddr = 0;
  logic bwr = 0, req_dropped = 1;
  int unsigned exp_next = 0, exp_left = 0;
  logic exp_write = 0;

  function automatic logic [31:0] pat(int k);
    return 32'hA5000000 ^ (32'(k) * 32'h00009E37);
  endfunction
  function automatic logic [31:0] gval(logic [31:0] a);
    return (a * 32'h01000193) ^ 32'h00005A5A;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  assign src_data = pat(src_k);

  always @(posedge clk) begin
    if (src_valid && src_ready) src_k <= src_k + 1;
    src_valid <= ($urandom % 4) != 0;
    if (snk_valid && snk_ready) begin got[got_n] = snk_data; got_n++; end
    snk_ready <= ($urandom % 4) != 0;
  end

  always @(posedge clk) begin
    if (!bus_req) begin bus_gnt <= 1'b0; req_dropped = 1; end
    else if (!bus_gnt && ($urandom % 3 == 0)) bus_gnt <= 1'b1;
    if (mem_cmd_valid) begin
      chk(mem_cmd_addr == exp_next, "R4 burst address", mem_cmd_addr, exp_next);
      chk(32'(mem_cmd_beats) == ((exp_left >= 4) ? 4 : exp_left), "R4 burst beats",
          32'(mem_cmd_beats), (exp_left >= 4) ? 4 : exp_left);
      chk(mem_cmd_write == exp_write, "R4 burst direction", 32'(mem_cmd_write), 32'(exp_write));
      if (xfer_cmds > 0) chk(req_dropped, "R3 request dropped between bursts", 32'(req_dropped), 1);
      exp_next += 32'(mem_cmd_beats) * 4;
      exp_left -= 32'(mem_cmd_beats);
      req_dropped = 0;
      bl = 32'(mem_cmd_beats); baddr = mem_cmd_addr; bwr = mem_cmd_write;
      cmd_cnt++; xfer_cmds++;
    end else if (bl > 0) begin
      if (bwr && mem_wvalid && mem_wready) begin
        mem[baddr[13:2]] = mem_wdata; baddr += 4; bl--;
      end else if (!bwr && mem_rvalid && mem_rready) begin
        baddr += 4; bl--;
      end
    end
    mem_wready <= ($urandom % 3) != 0;
    mem_rvalid <= (bl > 0) && !bwr && (($urandom % 3) != 0);
    mem_rdata  <= mem[baddr[13:2]];
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd3, st);
      if (!st[0]) return;
      @(negedge clk);
    end
    chk(0, "R7 transfer completion timeout", 0, 1);
  endtask

  task automatic run_xfer(input logic [31:0] a, input int len, input logic dir);
    logic [31:0] st, v;
    int base, bad;
    for (int i = 0; i < 4096; i++) mem[i] = gval(32'(i) << 2);
    got_n = 0; xfer_cmds = 0;
    exp_next = a; exp_left = len; exp_write = !dir;
    base = src_k;
    wr(2'd0, a); wr(2'd1, 32'(len));
    wr(2'd2, {30'd0, dir, 1'b1});
    wait_idle();
    if (!dir) base = src_k - len;
    rd(2'd3, st);
    chk(st == 32'h2, "R7 status done after last beat", st, 32'h2);
    chk(irq, "R7 irq high at completion", 32'(irq), 1);
    chk(xfer_cmds == (len + 3) / 4, "R4 burst count", xfer_cmds, (len + 3) / 4);
    bad = 0;
    if (!dir) begin
      for (int i = 0; i < len; i++) if (mem[(a[13:2] + i) % 4096] !== pat(base + i)) bad++;
      chk(bad == 0, "R5 memory contents", bad, 0);
      v = a + 32'(len * 4);
      chk(mem[v[13:2]] == gval({18'd0, v[13:2], 2'b00}), "R5 word after block untouched",
          mem[v[13:2]], gval({18'd0, v[13:2], 2'b00}));
    end else begin
      chk(got_n == len, "R6 sink word count", got_n, len);
      for (int i = 0; i < len; i++) if (got[i] !== gval(a + 32'(4 * i))) bad++;
      chk(bad == 0, "R6 sink data order", bad, 0);
    end
    wr(2'd3, 32'h2);
    rd(2'd3, st);
    chk(st == 0 && !irq, "R9 done cleared by write one", st, 0);
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
    chk(!irq && !bus_req && !mem_cmd_valid && !src_ready && !snk_valid, "R1 outputs idle",
        {irq, bus_req, mem_cmd_valid, src_ready, snk_valid}, 0);

    wr(2'd0, 32'h0000_0ABF); rd(2'd0, v);
    chk(v == 32'h0000_0ABC, "R2 address low bits read zero", v, 32'h0ABC);
    wr(2'd1, 32'd9); rd(2'd1, v);
    chk(v == 9, "R2 length readback", v, 9);
    wr(2'd2, 32'h2); rd(2'd2, v);
    chk(v == 2, "R2 direction readback", v, 2);
    rd(2'd3, v);
    chk(v == 0, "R2 direction write alone does not start", v, 0);

    run_xfer(32'h0000_0100, 1, 1'b0);
    run_xfer(32'h0000_0200, 4, 1'b1);
    run_xfer(32'h0000_1040, 5, 1'b0);
    run_xfer(32'h0000_2FE4, 7, 1'b1);
    run_xfer(32'h0000_0FE4, 7, 1'b0);

    // R8 page cross rejected
    c0 = cmd_cnt;
    wr(2'd0, 32'h0000_0FE8); wr(2'd1, 32'd7); wr(2'd2, 32'h1);
    rd(2'd3, v);
    chk(v == 32'h4, "R8 error set busy clear", v, 32'h4);
    chk(irq, "R8 irq on error", 32'(irq), 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_req) chk(0, "R8 no bus request after rejection", 1, 0);
    end
    chk(cmd_cnt == c0, "R8 no command issued", cmd_cnt, c0);
    wr(2'd3, 32'h2); rd(2'd3, v);
    chk(v == 32'h4 && irq, "R9 zero bit keeps error", v, 32'h4);
    wr(2'd3, 32'h4); rd(2'd3, v);
    chk(v == 0 && !irq, "R9 error cleared", v, 0);

    // R11 length zero
    wr(2'd0, 32'h0000_0300); wr(2'd1, 32'd0); wr(2'd2, 32'h1);
    rd(2'd3, v);
    chk(v == 32'h2, "R11 zero length done", v, 32'h2);
    repeat (10) @(negedge clk);
    chk(cmd_cnt == c0, "R11 no command issued", cmd_cnt, c0);
    wr(2'd3, 32'h6);

    // R10 writes while busy ignored
    for (int i = 0; i < 4096; i++) mem[i] = gval(32'(i) << 2);
    xfer_cmds = 0; exp_next = 32'h400; exp_left = 12; exp_write = 1;
    wr(2'd0, 32'h400); wr(2'd1, 32'd12); wr(2'd2, 32'h1);
    wr(2'd2, 32'h3); wr(2'd0, 32'h800); wr(2'd1, 32'd3);
    wait_idle();
    rd(2'd0, v); chk(v == 32'h400, "R10 address kept while busy", v, 32'h400);
    rd(2'd1, v); chk(v == 12, "R10 length kept while busy", v, 12);
    rd(2'd2, v); chk(v == 0, "R10 direction kept while busy", v, 0);
    chk(xfer_cmds == 3, "R10 second start ignored", xfer_cmds, 3);
    repeat (10) @(negedge clk);
    chk(xfer_cmds == 3 && !bus_req, "R10 no extra job", xfer_cmds, 3);
    wr(2'd3, 32'h2);

    // constrained random jobs
    void'($urandom(32'd1234));
    for (int t = 0; t < 10; t++) begin
      int len, off;
      logic [31:0] a;
      len = 1 + int'($urandom % 40);
      off = int'($urandom % (1025 - len));
      a = {18'd0, 2'(($urandom % 4)), 10'(off), 2'b00};
      run_xfer(a, len, 1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule